// File: doc/BRIEF.md
# Prioritized Interrupt Vector Unit

This block sits beside a small 8-bit processor core and chooses which of five hardware interrupt sources is served next. The sources are a non-maskable edge-detected trap line, a maskable edge-latched line, two maskable level lines and a general request line. The general request line is answered with an acknowledge strobe, and the device on the bus answers that strobe with a one-byte restart opcode. For each accepted request the unit produces a restart address and marks it with a one-cycle vector-valid pulse. The core then performs its own program-counter save and jump.

A maskable request can be accepted only while the interrupt-enable flag is set. Accepting one clears the flag, and software sets it again through `enSetIn`. The trap line ignores the flag and all mask bits. A set of pending bits shows the raw state of every source. After reset the vector output reads 0000H, which is where execution begins.

Top module: `irq_vector_unit`

## Requirements
- R1: After reset `vecAddr` is 0000H, `vecValid` is 0, `intaN` is 1, `intEnable` is 0 and `pendingBits` is 0 while all request inputs are low.
- R2: A rising edge on `trapIn` is latched and served with vector 0024H, even when `intEnable` is 0 and all mask bits are set. Serving the trap leaves `intEnable` unchanged. A trap line that stays high is not served a second time.
- R3: When several sources are eligible at once, the unit serves them in this order: trap, then the edge-latched line (`rst75In`), then `rst65In`, then `rst55In`, then `intrIn`.
- R4: The vector is 003CH for `rst75In`, 0034H for `rst65In` and 002CH for `rst55In`. Every vector lies below 0040H.
- R5: `maskIn` bit 2 masks `rst75In`, bit 1 masks `rst65In` and bit 0 masks `rst55In`, where 1 means masked. A masked source, and every source except the trap while `intEnable` is 0, is never served and does not raise `irqPending`.
- R6: A rising edge on `rst75In` sets `pendingBits[3]`. The bit stays set until that source is served or `clr75In` is pulsed, even after the input falls.
- R7: `pendingBits` bit 4 is the trap latch, bit 3 is the `rst75In` latch, and bits 2, 1 and 0 follow `rst65In`, `rst55In` and `intrIn` directly (level-sensitive). Mask bits have no effect on these bits.
- R8: Accepting `rst75In`, `rst65In`, `rst55In` or `intrIn` clears `intEnable`. This clear overrides an `enSetIn` pulse in the same cycle. `enClrIn` clears the flag and `enSetIn` sets it.
- R9: When `intrIn` is accepted, `intaN` goes low for exactly one cycle, starting the cycle after acceptance. `opIn` is sampled at the end of that cycle.
- R10: A sampled opcode of the form 11nnn111 produces vector nnn×8 (0xEF gives 0028H and 0xC7 gives 0000H). Any other opcode produces no vector, and the unit returns to idle.
- R11: `vecValid` is a one-cycle pulse. It is asserted in the cycle after a trap or restart-line acceptance, or in the cycle after the acknowledge cycle. It is never asserted while `intaN` is low, and `vecAddr` holds its value between pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| trapIn | input | 1 | Non-maskable trap request, rising-edge detected |
| rst75In | input | 1 | Maskable request, rising-edge latched |
| rst65In | input | 1 | Maskable request, level-sensitive |
| rst55In | input | 1 | Maskable request, level-sensitive |
| intrIn | input | 1 | General request, answered with acknowledge |
| maskIn | input | 3 | Mask bits for the three restart lines (1 = masked) |
| enSetIn | input | 1 | Pulse that sets the interrupt-enable flag |
| enClrIn | input | 1 | Pulse that clears the interrupt-enable flag |
| clr75In | input | 1 | Pulse that clears the edge latch of `rst75In` |
| opIn | input | 8 | Opcode byte from the data bus during acknowledge |
| irqPending | output | 1 | Some source is currently eligible for service |
| vecValid | output | 1 | One-cycle pulse marking a valid `vecAddr` |
| vecAddr | output | ADDR_W | Restart address for the core |
| intaN | output | 1 | Active-low acknowledge for `intrIn` |
| pendingBits | output | 5 | Raw pending state of the five sources |
| intEnable | output | 1 | Current interrupt-enable flag |

## Verification
On every cycle the assertions check the following. The valid pulse and the acknowledge strobe each last a single cycle, and they never overlap. Each acknowledge comes from a general request that was enabled, and it leaves the enable flag clear. Vectors stay within the restart table. The edge latch sets only after its input was seen high. Only the directed scenarios can show the rest. These are the exact vector chosen for each source, the priority order when sources collide, how the mask bits and enable flag gate each source, the decoding of the returned opcode, the rejection of a malformed opcode, and the precedence of the enable clear over a simultaneous set.

// File: rtl/irq_vec_pkg.sv
package irq_vec_pkg;

  localparam int OP_W  = 8;
  localparam int VEC_W = 6;

  typedef enum logic [2:0] {
    SRC_NONE, SRC_TRAP, SRC_R75, SRC_R65, SRC_R55
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_ACK, ST_VEC
  } state_e;

  // strobes from control to datapath
  typedef struct packed {
    logic clrTrap;
    logic clr75;
    logic dropEn;
    logic loadFixed;
    src_e srcSel;
    logic loadOpcode;
  } strobe_t;

  // fixed vectors expressed in units of four bytes
  function automatic logic [VEC_W-1:0] fixedVec(input src_e s);
    logic [3:0] quad;
    case (s)
      SRC_TRAP: quad = 4'd9;
      SRC_R75:  quad = 4'd15;
      SRC_R65:  quad = 4'd13;
      SRC_R55:  quad = 4'd11;
      default:  quad = 4'd0;
    endcase
    return {quad, 2'b00};
  endfunction

endpackage

// File: rtl/irq_vec_datapath.sv
module irq_vec_datapath
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapIn,
  input  logic              rst75In,
  input  logic              rst65In,
  input  logic              rst55In,
  input  logic              intrIn,
  input  logic [2:0]        maskIn,
  input  logic              enSetIn,
  input  logic              enClrIn,
  input  logic              clr75In,
  input  logic [OP_W-1:0]   opIn,
  input  strobe_t           stb,
  output logic [4:0]        eligible,
  output logic [4:0]        pendingBits,
  output logic              intEnable,
  output logic              opOk,
  output logic [ADDR_W-1:0] vecAddr
);

  localparam int PAD_W = ADDR_W - VEC_W;

  logic trapPrev, trapLatch;
  logic r75Prev, r75Latch;
  logic enReg;
  logic [VEC_W-1:0] vecReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      trapPrev  <= 1'b0;
      trapLatch <= 1'b0;
      r75Prev   <= 1'b0;
      r75Latch  <= 1'b0;
      enReg     <= 1'b0;
      vecReg    <= '0;
    end else begin
      trapPrev  <= trapIn;
      trapLatch <= (trapIn & ~trapPrev) | (trapLatch & ~stb.clrTrap);
      r75Prev   <= rst75In;
      r75Latch  <= (rst75In & ~r75Prev) | (r75Latch & ~(stb.clr75 | clr75In));
      if (stb.dropEn)    enReg <= 1'b0;
      else if (enSetIn)  enReg <= 1'b1;
      else if (enClrIn)  enReg <= 1'b0;
      if (stb.loadFixed)       vecReg <= fixedVec(stb.srcSel);
      else if (stb.loadOpcode) vecReg <= {opIn[5:3], 3'b000};
    end
  end

  assign pendingBits = {trapLatch, r75Latch, rst65In, rst55In, intrIn};
  assign eligible    = {trapLatch,
                        r75Latch & ~maskIn[2] & enReg,
                        rst65In  & ~maskIn[1] & enReg,
                        rst55In  & ~maskIn[0] & enReg,
                        intrIn   & enReg};
  assign opOk      = (opIn[7:6] == 2'b11) && (opIn[2:0] == 3'b111);
  assign intEnable = enReg;
  assign vecAddr   = {{PAD_W{1'b0}}, vecReg};

endmodule

// File: rtl/irq_vec_ctrl.sv
module irq_vec_ctrl
  import irq_vec_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [4:0] eligible,
  input  logic       opOk,
  output strobe_t    stb,
  output logic       intaN,
  output logic       vecValid
);

  state_e state, stateNext;

  always_comb begin
    stateNext      = state;
    stb.clrTrap    = 1'b0;
    stb.clr75      = 1'b0;
    stb.dropEn     = 1'b0;
    stb.loadFixed  = 1'b0;
    stb.srcSel     = SRC_NONE;
    stb.loadOpcode = 1'b0;
    case (state)
      ST_IDLE: begin
        if (eligible[4]) begin
          stb.clrTrap = 1'b1; stb.loadFixed = 1'b1; stb.srcSel = SRC_TRAP;
          stateNext = ST_VEC;
        end else if (eligible[3]) begin
          stb.clr75 = 1'b1; stb.dropEn = 1'b1; stb.loadFixed = 1'b1;
          stb.srcSel = SRC_R75; stateNext = ST_VEC;
        end else if (eligible[2]) begin
          stb.dropEn = 1'b1; stb.loadFixed = 1'b1; stb.srcSel = SRC_R65;
          stateNext = ST_VEC;
        end else if (eligible[1]) begin
          stb.dropEn = 1'b1; stb.loadFixed = 1'b1; stb.srcSel = SRC_R55;
          stateNext = ST_VEC;
        end else if (eligible[0]) begin
          stb.dropEn = 1'b1;
          stateNext = ST_ACK;
        end
      end
      ST_ACK: begin
        if (opOk) begin
          stb.loadOpcode = 1'b1;
          stateNext = ST_VEC;
        end else begin
          stateNext = ST_IDLE;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign intaN    = (state != ST_ACK);
  assign vecValid = (state == ST_VEC);

endmodule

// File: rtl/irq_vector_unit.sv
module irq_vector_unit
  import irq_vec_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trapIn,
  input  logic              rst75In,
  input  logic              rst65In,
  input  logic              rst55In,
  input  logic              intrIn,
  input  logic [2:0]        maskIn,
  input  logic              enSetIn,
  input  logic              enClrIn,
  input  logic              clr75In,
  input  logic [7:0]        opIn,
  output logic              irqPending,
  output logic              vecValid,
  output logic [ADDR_W-1:0] vecAddr,
  output logic              intaN,
  output logic [4:0]        pendingBits,
  output logic              intEnable
);

  strobe_t    stb;
  logic [4:0] eligible;
  logic       opOk;

  irq_vec_datapath #(.ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .trapIn(trapIn), .rst75In(rst75In),
    .rst65In(rst65In), .rst55In(rst55In), .intrIn(intrIn), .maskIn(maskIn),
    .enSetIn(enSetIn), .enClrIn(enClrIn), .clr75In(clr75In), .opIn(opIn),
    .stb(stb), .eligible(eligible), .pendingBits(pendingBits),
    .intEnable(intEnable), .opOk(opOk), .vecAddr(vecAddr)
  );

  irq_vec_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .eligible(eligible), .opOk(opOk),
    .stb(stb), .intaN(intaN), .vecValid(vecValid)
  );

  assign irqPending = |eligible;

endmodule

// File: rtl/irq_vec_checker.sv
module irq_vec_checker #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              rst75In,
  input logic              intrIn,
  input logic              vecValid,
  input logic [ADDR_W-1:0] vecAddr,
  input logic              intaN,
  input logic [4:0]        pendingBits,
  input logic              intEnable
);

  assert_vec_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |=> !vecValid);

  assert_no_overlap_R11: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> intaN);

  assert_inta_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    !intaN |=> intaN);

  assert_inta_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intaN) |-> ($past(intrIn) && $past(intEnable)));

  assert_inta_drops_enable_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(intaN) |-> !intEnable);

  assert_vec_range_R4: assert property (@(posedge clk) disable iff (!rstN)
    vecValid |-> (vecAddr < ADDR_W'(64)));

  assert_latch_source_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pendingBits[3]) |-> $past(rst75In));

endmodule

bind irq_vector_unit irq_vec_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .rst75In(rst75In), .intrIn(intrIn),
  .vecValid(vecValid), .vecAddr(vecAddr), .intaN(intaN),
  .pendingBits(pendingBits), .intEnable(intEnable)
);

// File: tb/sim_irq_vector_unit.sv
`timescale 1ns/1ps
module sim_irq_vector_unit;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        trapIn = 0, rst75In = 0, rst65In = 0, rst55In = 0, intrIn = 0;
  logic [2:0]  maskIn = 3'b000;
  logic        enSetIn = 0, enClrIn = 0, clr75In = 0;
  logic [7:0]  opIn = 8'h00;
  logic        irqPending, vecValid, intaN, intEnable;
  logic [15:0] vecAddr;
  logic [4:0]  pendingBits;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  irq_vector_unit u0 (
    .clk(clk), .rstN(rstN), .trapIn(trapIn), .rst75In(rst75In),
    .rst65In(rst65In), .rst55In(rst55In), .intrIn(intrIn), .maskIn(maskIn),
    .enSetIn(enSetIn), .enClrIn(enClrIn), .clr75In(clr75In), .opIn(opIn),
    .irqPending(irqPending), .vecValid(vecValid), .vecAddr(vecAddr),
    .intaN(intaN), .pendingBits(pendingBits), .intEnable(intEnable)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulseSet();
    @(negedge clk) enSetIn = 1;
    @(negedge clk) enSetIn = 0;
  endtask

  task automatic pulseClr();
    @(negedge clk) enClrIn = 1;
    @(negedge clk) enClrIn = 0;
  endtask

  task automatic waitVec(input int maxCyc, output bit got, output logic [15:0] addr);
    got = 0; addr = '0;
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (vecValid) begin got = 1; addr = vecAddr; break; end
    end
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 vecAddr", 32'(vecAddr), 32'h0000);
    chk("R1 vecValid", 32'(vecValid), 0);
    chk("R1 intaN", 32'(intaN), 1);
    chk("R1 intEnable", 32'(intEnable), 0);
    chk("R1 pendingBits", 32'(pendingBits), 0);
  endtask

  task automatic testTrap();
    bit got; logic [15:0] a;
    maskIn = 3'b111;
    @(negedge clk) trapIn = 1;
    waitVec(6, got, a);
    chk("R2 trap taken with enable off", 32'(got), 1);
    chk("R2 trap vector", 32'(a), 32'h0024);
    waitVec(5, got, a);
    chk("R2 held trap not retaken", 32'(got), 0);
    chk("R2 trap latch cleared", 32'(pendingBits[4]), 0);
    @(negedge clk) trapIn = 0;
    pulseSet();
    @(negedge clk) trapIn = 1;
    waitVec(6, got, a);
    chk("R2 trap vector with enable on", 32'(a), 32'h0024);
    chk("R2 trap keeps enable", 32'(intEnable), 1);
    @(negedge clk) trapIn = 0;
    pulseClr();
    maskIn = 3'b000;
  endtask

  task automatic testLevels();
    bit got; logic [15:0] a;
    @(negedge clk) begin rst65In = 1; rst55In = 1; end
    @(negedge clk);
    chk("R7 level pending bits", 32'(pendingBits), 32'b00110);
    chk("R5 no pending while disabled", 32'(irqPending), 0);
    pulseSet();
    waitVec(5, got, a);
    chk("R3 rst65 before rst55", 32'(a), 32'h0034);
    chk("R8 enable dropped", 32'(intEnable), 0);
    waitVec(4, got, a);
    chk("R5 disabled level not retaken", 32'(got), 0);
    maskIn = 3'b010;
    @(negedge clk);
    chk("R7 mask has no effect on pending", 32'(pendingBits), 32'b00110);
    pulseSet();
    waitVec(5, got, a);
    chk("R4 rst55 vector with rst65 masked", 32'(a), 32'h002C);
    @(negedge clk) begin rst65In = 0; rst55In = 0; maskIn = 3'b000; end
  endtask

  task automatic testEdgeLatch();
    bit got; logic [15:0] a;
    @(negedge clk) rst75In = 1;
    @(negedge clk) rst75In = 0;
    @(negedge clk);
    chk("R6 latch holds after input falls", 32'(pendingBits[3]), 1);
    maskIn = 3'b100;
    pulseSet();
    waitVec(4, got, a);
    chk("R5 masked latch not served", 32'(got), 0);
    chk("R6 latch still set while masked", 32'(pendingBits[3]), 1);
    maskIn = 3'b000;
    waitVec(4, got, a);
    chk("R4 rst75 vector", 32'(a), 32'h003C);
    chk("R6 latch cleared by service", 32'(pendingBits[3]), 0);
    @(negedge clk) rst75In = 1;
    @(negedge clk) rst75In = 0;
    @(negedge clk) clr75In = 1;
    @(negedge clk) clr75In = 0;
    chk("R6 explicit clear", 32'(pendingBits[3]), 0);
    pulseSet();
    waitVec(4, got, a);
    chk("R6 cleared latch not served", 32'(got), 0);
    // trap and rst75 together, enable on
    @(negedge clk) begin trapIn = 1; rst75In = 1; end
    waitVec(6, got, a);
    chk("R3 trap first", 32'(a), 32'h0024);
    waitVec(6, got, a);
    chk("R3 rst75 second", 32'(a), 32'h003C);
    @(negedge clk) begin trapIn = 0; rst75In = 0; end
  endtask

  task automatic intrCycle(input logic [7:0] op, output bit got, output logic [15:0] a);
    int lowCount = 0;
    pulseSet();
    intrIn = 1;
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      if (!intaN) break;
    end
    chk("R9 acknowledge asserted", 32'(intaN), 0);
    opIn = op;
    @(negedge clk);
    intrIn = 0;
    chk("R9 acknowledge lasts one cycle", 32'(intaN), 1);
    chk("R8 enable dropped by general request", 32'(intEnable), 0);
    got = vecValid; a = vecAddr;
    lowCount = 0;
  endtask

  task automatic testIntr();
    bit got; logic [15:0] a;
    intrCycle(8'hEF, got, a);
    chk("R10 opcode EF valid", 32'(got), 1);
    chk("R10 opcode EF vector", 32'(a), 32'h0028);
    intrCycle(8'hC7, got, a);
    chk("R10 opcode C7 vector", 32'(a), 32'h0000);
    chk("R11 vecValid after ack", 32'(got), 1);
    intrCycle(8'hC3, got, a);
    chk("R10 malformed opcode ignored", 32'(got), 0);
    waitVec(4, got, a);
    chk("R10 no late vector", 32'(got), 0);
    chk("R11 vecAddr holds", 32'(vecAddr), 32'h0000);
  endtask

  task automatic testRace();
    bit got; logic [15:0] a;
    pulseSet();
    @(negedge clk) begin rst55In = 1; enSetIn = 1; end
    @(negedge clk) enSetIn = 0;
    got = vecValid; a = vecAddr;
    chk("R11 vector one cycle after acceptance", 32'(got), 1);
    chk("R4 rst55 vector", 32'(a), 32'h002C);
    chk("R8 clear overrides set", 32'(intEnable), 0);
    @(negedge clk);
    chk("R11 pulse is one cycle", 32'(vecValid), 0);
    rst55In = 0;
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1;
    testReset();
    testTrap();
    testLevels();
    testEdgeLatch();
    testIntr();
    testRace();
    repeat (2) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

endmodule